// File: doc/BRIEF.md
# Auxiliary Successive-Approximation Converter Controller

This block is the digital sequencer for one 8-bit successive-approximation converter that serves four multiplexed analog inputs. It picks the input channel from one of two places, chosen by a source bit: a pair of select pins or a pair of register bits. When the enable input rises, it captures the channel, powers the converter up and searches the code space from MSB to LSB. The search uses a single comparator bit that reports whether the sampled input is at least the current trial code. The analog multiplexer, trial DAC and comparator lie outside the block. The block drives them through `chan_sel`, `trial_code` and `pwr_on`, and reads the comparator on `cmp_ge`.

When the last bit has been resolved, `done` rises. From then on, the result leaves MSB first on `ser_data`, one bit for each rising edge of the externally supplied `ser_clk`. Whenever the block is not converting, the converter is unpowered and every output is held low. If enable drops at any point, the block aborts to idle at once.

The state machine has four states. `ST_IDLE` is powered down. `ST_TRY` drives a trial code. `ST_JUDGE` waits for the comparator to settle and then keeps or drops the trial bit. `ST_SHIFT` holds the result and shifts it out. Its transitions are:
- start: from `ST_IDLE` to `ST_TRY`, on a rising enable.
- settle: from `ST_TRY` to `ST_JUDGE`.
- next-bit: from `ST_JUDGE` to `ST_TRY`, while bits remain.
- finish: from `ST_JUDGE` to `ST_SHIFT`, after the LSB.
- abort: from any state to `ST_IDLE`, when enable is low.

Top module: `aux_sar_ctrl`

## Requirements
- R1: After reset, and whenever idle, `pwr_on`, `done`, `ser_data`, `trial_code` and `chan_sel` are all zero.
- R2: With `src_sel_reg`=0 the channel comes from `sel_pins`; the 2-bit code n (0..3) selects analog input n and appears unchanged on `chan_sel`.
- R3: With `src_sel_reg`=1 the channel comes from `sel_bits`, with the same code-to-input mapping as R2.
- R4: The channel is captured on the cycle the rising enable is seen. Later changes on `sel_pins`, `sel_bits` or `src_sel_reg` do not alter `chan_sel` before the conversion ends.
- R5: For an input value v (0..255) with `cmp_ge` = (v >= `trial_code`), the converted result equals v.
- R6: Each bit position is tried for two clock cycles, MSB first. The trial code is the kept upper bits with the current bit set and the lower bits clear, so the first trial code is 0x80. The comparator is sampled on the second cycle.
- R7: `pwr_on` is high from the cycle after the start edge. `done` rises exactly 16 cycles after that edge and stays high while enable stays high.
- R8: After `done`, `ser_data` shows result bit 7. Each rising edge of `ser_clk` advances to the next lower bit, and after eight edges `ser_data` is 0.
- R9: Edges on `ser_clk` before `done` are ignored, and `ser_data` stays low until `done`.
- R10: Enable low at a clock edge returns the block to idle at that edge, with all outputs low. A later rising enable starts a fresh conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Conversion enable; rising edge starts, low aborts/idles |
| src_sel_reg | input | 1 | Channel source: 0 = pins, 1 = register bits |
| sel_pins | input | 2 | Channel select from pins |
| sel_bits | input | 2 | Channel select from register bits |
| cmp_ge | input | 1 | Comparator: analog input >= trial code |
| ser_clk | input | 1 | External serial data clock (synchronous to clk) |
| pwr_on | output | 1 | Converter power enable |
| chan_sel | output | 2 | Analog multiplexer select |
| trial_code | output | 8 | Trial DAC code |
| done | output | 1 | Conversion complete, result available |
| ser_data | output | 1 | Serial result, MSB first |

## Verification
The enable level is sampled on a clock edge. `pwr_on`, `chan_sel` and the first trial code 0x80 follow one edge later, and each later trial code holds for two cycles. `done` appears on the sixteenth edge after the start edge. Inputs are driven on falling edges and outputs are sampled on the falling edge after the edge that updates them. In that way the trial code is compared with its expected value on every one of the 16 conversion cycles, and `done` is checked low on cycle 16 and high on cycle 17. Each `ser_clk` rise is seen on the next clock edge, so each serial bit is read on the falling edge that follows. An abort is checked one edge after enable is lowered.

// File: rtl/aux_sar_pkg.sv
package aux_sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRY   = 2'd1,
        ST_JUDGE = 2'd2,
        ST_SHIFT = 2'd3
    } sar_state_t;

endpackage

// File: rtl/aux_sar_chan.sv
module aux_sar_chan #(
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              clear,
    input  logic              src_reg,
    input  logic [CHAN_W-1:0] sel_pins,
    input  logic [CHAN_W-1:0] sel_bits,
    output logic [CHAN_W-1:0] chan_q
);

    logic [CHAN_W-1:0] chan_pick;

    always_comb begin
        chan_pick = src_reg ? sel_bits : sel_pins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (clear) begin
            chan_q <= '0;
        end else if (capture) begin
            chan_q <= chan_pick;
        end
    end

endmodule

// File: rtl/aux_sar_shift.sv
module aux_sar_shift #(
    parameter int RES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           load,
    input  logic [RES-1:0] load_val,
    input  logic           adv,
    output logic           msb
);

    logic [RES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (adv) begin
            sh_q <= {sh_q[RES-2:0], 1'b0};
        end
    end

    always_comb begin
        msb = sh_q[RES-1];
    end

endmodule

// File: rtl/aux_sar_ctrl.sv
module aux_sar_ctrl
    import aux_sar_pkg::*;
#(
    parameter int RES    = 8,
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_en,
    input  logic              src_sel_reg,
    input  logic [CHAN_W-1:0] sel_pins,
    input  logic [CHAN_W-1:0] sel_bits,
    input  logic              cmp_ge,
    input  logic              ser_clk,
    output logic              pwr_on,
    output logic [CHAN_W-1:0] chan_sel,
    output logic [RES-1:0]    trial_code,
    output logic              done,
    output logic              ser_data
);

    localparam int                IDX_W   = (RES > 1) ? $clog2(RES) : 1;
    localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(RES - 1);
    localparam logic [RES-1:0]    ONE     = {{(RES-1){1'b0}}, 1'b1};

    sar_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [RES-1:0]    res_q;
    logic              en_q;
    logic              sclk_q;

    logic              start;
    logic              sclk_rise;
    logic [RES-1:0]    trial_bit;
    logic [RES-1:0]    res_try;
    logic [RES-1:0]    res_kept;
    logic              last_bit;
    logic              sh_load;
    logic              sh_adv;
    logic              sh_clear;
    logic              sh_msb;
    logic              chan_clear;

    always_comb begin
        start     = conv_en & ~en_q;
        sclk_rise = ser_clk & ~sclk_q;
        trial_bit = ONE << idx_q;
        res_try   = res_q | trial_bit;
        res_kept  = cmp_ge ? res_try : res_q;
        last_bit  = (idx_q == '0);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_TRY;
            ST_TRY:   state_d = ST_JUDGE;
            ST_JUDGE: state_d = last_bit ? ST_SHIFT : ST_TRY;
            ST_SHIFT: state_d = ST_SHIFT;
            default:  state_d = ST_IDLE;
        endcase
        if (!conv_en) begin
            state_d = ST_IDLE;
        end
    end

    // State register and search registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= TOP_IDX;
            res_q   <= '0;
            en_q    <= 1'b0;
            sclk_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= conv_en;
            sclk_q  <= ser_clk;
            if (!conv_en) begin
                res_q <= '0;
                idx_q <= TOP_IDX;
            end else if (state_q == ST_IDLE && start) begin
                res_q <= '0;
                idx_q <= TOP_IDX;
            end else if (state_q == ST_JUDGE) begin
                res_q <= res_kept;
                if (!last_bit) begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    // Output logic
    always_comb begin
        pwr_on     = 1'b0;
        trial_code = '0;
        done       = 1'b0;
        sh_load    = 1'b0;
        sh_adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_TRY: begin
                pwr_on     = 1'b1;
                trial_code = res_try;
            end
            ST_JUDGE: begin
                pwr_on     = 1'b1;
                trial_code = res_try;
                sh_load    = last_bit & conv_en;
            end
            ST_SHIFT: begin
                pwr_on = 1'b1;
                done   = 1'b1;
                sh_adv = sclk_rise & conv_en;
            end
            default: begin
            end
        endcase
        sh_clear   = (state_d == ST_IDLE);
        chan_clear = (state_d == ST_IDLE);
        ser_data   = sh_msb & done;
    end

    aux_sar_chan #(.CHAN_W(CHAN_W)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (start && state_q == ST_IDLE),
        .clear    (chan_clear),
        .src_reg  (src_sel_reg),
        .sel_pins (sel_pins),
        .sel_bits (sel_bits),
        .chan_q   (chan_sel)
    );

    aux_sar_shift #(.RES(RES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clear),
        .load     (sh_load),
        .load_val (res_kept),
        .adv      (sh_adv),
        .msb      (sh_msb)
    );

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> (!pwr_on && !ser_data && !done && chan_sel == '0)); // R10

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && $past(pwr_on)) |-> $stable(chan_sel)); // R4

    AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |-> (trial_code == (ONE << (RES - 1)))); // R6

    AST_SER_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_data |-> done); // R9

    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && conv_en) |=> done); // R7

endmodule

// File: tb/tb_aux_sar_ctrl.sv
module tb_aux_sar_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       conv_en;
    logic       src_sel_reg;
    logic [1:0] sel_pins;
    logic [1:0] sel_bits;
    logic       cmp_ge;
    logic       ser_clk;
    logic       pwr_on;
    logic [1:0] chan_sel;
    logic [7:0] trial_code;
    logic       done;
    logic       ser_data;
    logic [7:0] vin;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    assign cmp_ge = (vin >= trial_code);

    aux_sar_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_en     (conv_en),
        .src_sel_reg (src_sel_reg),
        .sel_pins    (sel_pins),
        .sel_bits    (sel_bits),
        .cmp_ge      (cmp_ge),
        .ser_clk     (ser_clk),
        .pwr_on      (pwr_on),
        .chan_sel    (chan_sel),
        .trial_code  (trial_code),
        .done        (done),
        .ser_data    (ser_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        chk(pwr_on == 1'b0 && done == 1'b0 && ser_data == 1'b0, req,
            {pwr_on, done, ser_data}, 0);
        chk(trial_code == 8'h00 && chan_sel == 2'b00, req,
            {trial_code, chan_sel}, 0);
    endtask

    task automatic run_conv(input logic [7:0] v, input bit noisy);
        logic [1:0] exp_ch;
        vin         = v;
        src_sel_reg = v[0];
        sel_pins    = v[2:1];
        sel_bits    = ~v[2:1];
        exp_ch      = v[0] ? ~v[2:1] : v[2:1];
        conv_en     = 1'b1;
        for (int c = 1; c <= 16; c++) begin
            int         idx;
            logic [7:0] exp_tr;
            step();
            idx    = 7 - (c - 1) / 2;
            exp_tr = (v & (8'hFF << (idx + 1))) | (8'h01 << idx);
            chk(trial_code == exp_tr, "R6 trial code", trial_code, exp_tr);
            if (c == 1) begin
                chk(pwr_on == 1'b1, "R7 power up", pwr_on, 1);
                chk(chan_sel == exp_ch, v[0] ? "R3 reg channel" : "R2 pin channel",
                    chan_sel, exp_ch);
                sel_pins    = ~sel_pins;
                sel_bits    = ~sel_bits;
                src_sel_reg = ~src_sel_reg;
            end
            if (noisy && c < 12) begin
                ser_clk = ~ser_clk;
            end else begin
                ser_clk = 1'b0;
            end
            chk(ser_data == 1'b0, "R9 quiet before done", ser_data, 0);
        end
        chk(done == 1'b0, "R7 done not early", done, 0);
        step();
        chk(done == 1'b1, "R7 done timing", done, 1);
        chk(chan_sel == exp_ch, "R4 channel held", chan_sel, exp_ch);
        for (int b = 7; b >= 0; b--) begin
            chk(ser_data == v[b], "R5 R8 serial bit", ser_data, v[b]);
            ser_clk = 1'b1;
            step();
            ser_clk = 1'b0;
            step();
        end
        chk(ser_data == 1'b0, "R8 trailing zero", ser_data, 0);
        chk(done == 1'b1, "R7 done holds", done, 1);
        conv_en = 1'b0;
        step();
        check_idle("R1 idle after conversion");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        conv_en     = 1'b0;
        src_sel_reg = 1'b0;
        sel_pins    = 2'b00;
        sel_bits    = 2'b00;
        ser_clk     = 1'b0;
        vin         = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1 reset state");
        step();
        check_idle("R1 idle without enable");

        for (int v = 0; v < 256; v++) begin
            run_conv(v[7:0], v[3]);
        end

        // R10: abort mid-search, then restart cleanly
        vin         = 8'hA5;
        src_sel_reg = 1'b0;
        sel_pins    = 2'b11;
        conv_en     = 1'b1;
        repeat (5) step();
        chk(pwr_on == 1'b1, "R10 running before abort", pwr_on, 1);
        conv_en = 1'b0;
        step();
        check_idle("R10 abort to idle");
        step();
        check_idle("R10 stays idle");
        run_conv(8'h3C, 1'b0);

        // R10: abort during shifting
        conv_en = 1'b1;
        vin     = 8'hFF;
        repeat (17) step();
        chk(ser_data == 1'b1, "R8 msb of 0xFF", ser_data, 1);
        conv_en = 1'b0;
        step();
        check_idle("R10 abort during shift");
        run_conv(8'h81, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule